// File: doc/BRIEF.md
# Zero-Run Expanding Serial Loader

This block takes a compressed byte stream and turns it into a serial bit stream with its own bit clock, as used to shift a configuration image into a programmable device. Bytes come in over a valid/ready handshake. A byte other than zero is sent as its eight bits, most significant first. A zero byte is a run marker. The byte after it gives a count, and the pair becomes count × 8 zero bits. No data is stored for the run: a bit counter only counts down.

A zero marker followed by a zero count ends the stream. The block then stops its bit clock and raises a done flag. A marker with count 4 is an ordinary run, so a trailing 32-bit zero pad before the terminator needs no special handling. A start pulse clears all state and opens the block for a new stream. After reset, the block waits for that pulse.

Top module: `zrun_serial_loader`

## Requirements
- R1: A non-zero accepted byte produces exactly 8 bit-clock pulses, carrying the byte's bits from bit 7 down to bit 0.
- R2: A zero byte followed by a count byte c, with 1 ≤ c ≤ 255, produces exactly 8·c pulses with data 0. At c = 255 that is 2040 bits.
- R3: `in_ready` is low whenever the bit clock is high, and stays low until the last bit of the current byte or run has finished. A byte offered during that time is not taken.
- R4: `sclk` runs at half the system rate. Each bit is one cycle low followed by one cycle high, and `sclk` is never high in two consecutive cycles.
- R5: `sdata` holds the same value during the low cycle and the high cycle of each bit.
- R6: When the count after a zero marker is also zero, `done` is high in the cycle after that count is accepted. From then until the next start, `sclk` stays low and `in_ready` stays low.
- R7: The pair zero, 4 gives 32 zero bits, and a terminator that follows it still ends the stream normally.
- R8: After reset, `done`, `sclk` and `in_ready` are all low, and nothing is accepted until `start` is pulsed.
- R9: A `start` pulse in any state, including in the middle of a run or after done, gives `in_ready` high, `done` low and `sclk` low in the next cycle. The stream that follows is decoded from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that clears state and opens a new stream |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Compressed stream byte |
| in_ready | output | 1 | Block takes the byte on this edge if in_valid is high |
| sdata | output | 1 | Serial data bit |
| sclk | output | 1 | Serial bit clock; the receiver samples on its rising edge |
| done | output | 1 | Terminator seen; the stream is complete |

## Verification
The first bit of a byte appears on `sdata` in the cycle right after the byte is accepted. `sclk` rises one cycle later. Each bit then takes two cycles. `in_ready` comes back the cycle after the last high phase, so a byte or run of n bits takes 2n+1 cycles from one acceptance to the next. `done` follows the accepting edge of the terminating count by one cycle, and a start pulse shows its effect one cycle later. The bench drives and samples on the falling clock edge. It captures a bit only on the first high cycle of `sclk`, so the bit stream is compared whatever the exact gaps between bytes. It checks `done`, `in_ready` and `sclk` exactly one falling edge after the accepting edge or the start pulse that causes them.

// File: rtl/zrun_serial_loader.sv
module zrun_serial_loader (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       sdata,
  output logic       sclk,
  output logic       done
);
  localparam int CNT_W = 11;

  typedef enum logic [2:0] {S_IDLE, S_BYTE, S_COUNT, S_SHIFT, S_DONE} state_t;

  state_t           state;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] bits_left;
  logic             phase;
  logic             take;

  assign in_ready = (state == S_BYTE) || (state == S_COUNT);
  assign take     = in_valid && in_ready;
  assign sclk     = (state == S_SHIFT) && phase;
  assign sdata    = (state == S_SHIFT) && shreg[7];
  assign done     = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      phase     <= 1'b0;
    end else if (start) begin
      state     <= S_BYTE;
      shreg     <= '0;
      bits_left <= '0;
      phase     <= 1'b0;
    end else begin
      case (state)
        S_BYTE: if (take) begin
          if (in_byte != 8'd0) begin
            shreg     <= in_byte;
            bits_left <= CNT_W'(8);
            phase     <= 1'b0;
            state     <= S_SHIFT;
          end else begin
            state <= S_COUNT;
          end
        end
        S_COUNT: if (take) begin
          if (in_byte == 8'd0) begin
            state <= S_DONE;
          end else begin
            shreg     <= '0;
            bits_left <= {in_byte, 3'b000};
            phase     <= 1'b0;
            state     <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          phase <= !phase;
          if (phase) begin
            shreg     <= {shreg[6:0], 1'b0};
            bits_left <= bits_left - CNT_W'(1);
            if (bits_left == CNT_W'(1)) state <= S_BYTE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/zrun_serial_loader_chk.sv
module zrun_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_ready,
  input logic sdata,
  input logic sclk,
  input logic done
);
  a_r3_ready_low_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !in_ready);

  a_r4_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && !in_ready));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_ready && !done && !sclk));
endmodule

bind zrun_serial_loader zrun_serial_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .sdata(sdata), .sclk(sclk), .done(done)
);

// File: tb/zrun_serial_loader_tb_top.sv
`timescale 1ns/1ps
module zrun_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic in_ready, sdata, sclk, done;

  always #2.5 clk = ~clk;

  zrun_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .sdata(sdata), .sclk(sclk), .done(done)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic prev_sclk = 1'b0;
  logic prev_sdata = 1'b0;
  int err_double = 0;
  int err_unstable = 0;
  int err_overlap = 0;
  bit got_q[$];
  bit exp_q[$];
  logic [7:0] stream_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk && !prev_sclk) got_q.push_back(sdata);
      if (sclk && prev_sclk) err_double++;
      if (sclk && (sdata !== prev_sdata)) err_unstable++;
      if (sclk && in_ready) err_overlap++;
    end
    prev_sclk = sclk;
    prev_sdata = sdata;
    if (cyc > 190000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(in_ready === 1'b1 && done === 1'b0 && sclk === 1'b0, "R9 start opens stream",
          {in_ready, done, sclk}, 3'b100);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte = b;
    forever begin
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic build_exp();
    exp_q.delete();
    for (int i = 0; i < stream_q.size(); i++) begin
      if (stream_q[i] != 8'd0) begin
        for (int k = 7; k >= 0; k--) exp_q.push_back(stream_q[i][k]);
      end else begin
        i++;
        if (stream_q[i] == 8'd0) break;
        for (int k = 0; k < 8 * int'(stream_q[i]); k++) exp_q.push_back(1'b0);
      end
    end
  endtask

  task automatic run_stream(input string tag);
    int zeros_exp;
    int nbits;
    pulse_start();
    got_q.delete();
    err_double = 0; err_unstable = 0; err_overlap = 0;
    build_exp();
    for (int i = 0; i < stream_q.size(); i++) send_byte(stream_q[i]);
    check(done === 1'b1, {tag, " R6 done after terminator"}, done, 1);
    nbits = got_q.size();
    repeat (12) begin
      @(negedge clk);
    end
    check(got_q.size() == nbits && in_ready === 1'b0 && done === 1'b1,
          {tag, " R6 quiet after done"}, got_q.size(), nbits);
    check(got_q.size() == exp_q.size(), {tag, " R1 R2 bit count"}, got_q.size(), exp_q.size());
    zeros_exp = 0;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] != exp_q[i]) zeros_exp++;
    check(zeros_exp == 0, {tag, " R1 R2 bit content mismatches"}, zeros_exp, 0);
    check(err_double == 0, {tag, " R4 sclk high twice in a row"}, err_double, 0);
    check(err_unstable == 0, {tag, " R5 sdata changed at sclk high"}, err_unstable, 0);
    check(err_overlap == 0, {tag, " R3 ready while clocking"}, err_overlap, 0);
  endtask

  initial begin
    int t0;
    void'($urandom(32'h5EED_0001));
    repeat (3) @(negedge clk);
    check(done === 1'b0 && sclk === 1'b0 && in_ready === 1'b0, "R8 reset state",
          {done, sclk, in_ready}, 0);
    rst_n = 1'b1;
    in_valid = 1'b1; in_byte = 8'hA5;
    repeat (5) @(negedge clk);
    check(in_ready === 1'b0 && sclk === 1'b0, "R8 idle until start", {in_ready, sclk}, 0);
    in_valid = 1'b0;

    stream_q = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h00};
    run_stream("direct-bytes");

    stream_q = '{8'h3C, 8'h00, 8'hFF, 8'h81, 8'h00, 8'h00};
    run_stream("R2 max run 2040");

    stream_q = '{8'h7E, 8'h00, 8'h04, 8'h00, 8'h00};
    run_stream("R7 pad pair");

    stream_q = '{8'h00, 8'h00};
    run_stream("R6 empty stream");

    // R3 timing: a run of 3 bytes (24 bits) keeps ready low 48 cycles plus the accept cycle
    pulse_start();
    send_byte(8'h00);
    send_byte(8'h03);
    t0 = cyc;
    send_byte(8'h55);
    check(cyc - t0 == 49, "R3 next byte taken after run", cyc - t0, 49);
    send_byte(8'h00);
    send_byte(8'h00);

    // R9 abort in the middle of a run, then restart after done
    pulse_start();
    send_byte(8'h00);
    send_byte(8'hFF);
    repeat (100) @(negedge clk);
    check(sclk === 1'b1 || sclk === 1'b0, "R9 mid-run", 1, 1);
    pulse_start();
    stream_q = '{8'h12, 8'h00, 8'h00};
    run_stream("R9 after abort");
    pulse_start();
    check(done === 1'b0, "R9 start clears done", done, 0);

    for (int s = 0; s < 20; s++) begin
      int n;
      n = 5 + ($urandom % 20);
      stream_q.delete();
      for (int i = 0; i < n; i++) begin
        if (($urandom % 10) < 3) begin
          stream_q.push_back(8'h00);
          stream_q.push_back(8'(1 + ($urandom % 40)));
        end else begin
          stream_q.push_back(8'(1 + ($urandom % 255)));
        end
      end
      if ($urandom % 2) begin
        stream_q.push_back(8'h00);
        stream_q.push_back(8'h04);
      end
      stream_q.push_back(8'h00);
      stream_q.push_back(8'h00);
      run_stream($sformatf("random-%0d", s));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule